// File: doc/BRIEF.md
# Programmable Peripheral Strobe Timing Sequencer

The sequencer converts one read or write request from a host-side register port into a single access on a slow peripheral bus. Each access has three phases in a fixed order. A setup phase raises chip select and drives the address. A strobe phase pulses the read or the write strobe. A hold phase drops the strobe while address and chip select stay valid. Each phase lasts a number of clock cycles taken from a 14-bit timing word. The strobe phase has one length field for reads and a separate one for writes.

The timing word also chooses the width of the peripheral data path, 8 or 16 bits, and can swap the two bytes of halfword data. A write drives its data for the whole access. A read samples the peripheral data bus in the last strobe cycle. The timing word, direction, address and write data are all latched when the request is accepted, so the host may change its inputs while the access runs.

Top module: `pio_strobe_seq`

## Requirements
- R1: After reset `busy`, `done`, `per_cs`, `per_rd`, `per_wr` and `per_doe` are low, and `per_addr`, `per_dout` and `rsp_rdata` are zero.
- R2: A request with `req_valid` high while `busy` is low is accepted at that clock edge. From the next cycle the setup phase runs for `cfg_timing[11:9]`+1 cycles, with `per_cs` high, `per_addr` equal to the accepted address and both strobes low.
- R3: For a write, the strobe phase holds `per_wr` high for `cfg_timing[4:2]`+1 cycles, and `per_rd` stays low.
- R4: For a read, the strobe phase holds `per_rd` high for `cfg_timing[8:5]`+1 cycles, and `per_wr` stays low.
- R5: The hold phase follows the strobe phase and lasts `cfg_timing[1:0]`+1 cycles, with `per_cs` high, the address unchanged and both strobes low.
- R6: A read samples `per_din` at the clock edge that ends the last strobe cycle. `rsp_rdata` shows that value from the next cycle and keeps it until the next read sample.
- R7: During a write, `per_doe` is high and `per_dout` carries the write data from the first setup cycle through the last hold cycle. At all other times `per_doe` is low and `per_dout` is zero.
- R8: `busy` is high in every setup, strobe and hold cycle. `done` is high for exactly one cycle, the cycle right after the last hold cycle, and `busy` is low in that cycle. A request presented in the `done` cycle is accepted.
- R9: A request presented while `busy` is high is ignored: address, direction and data of the running access do not change.
- R10: `cfg_timing[12]`=1 selects 16-bit accesses. With 0, only bits 7:0 carry data: `per_dout[15:8]` is zero and `rsp_rdata[15:8]` reads zero.
- R11: `cfg_timing[13]`=1 in 16-bit mode exchanges the two bytes in both directions. In 8-bit mode the bit has no effect.
- R12: The timing word is sampled only at acceptance. Changing `cfg_timing` during an access does not alter its phase lengths or data format.
- R13: `per_rd` and `per_wr` are never high together, and a strobe is only high while `per_cs` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_timing | input | 14 | Phase lengths, width and swap selection |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (8) | Peripheral address of the access |
| req_wdata | input | DW (16) | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rsp_rdata | output | DW (16) | Last read result |
| per_addr | output | AW (8) | Peripheral address bus |
| per_cs | output | 1 | Peripheral chip select |
| per_rd | output | 1 | Read strobe |
| per_wr | output | 1 | Write strobe |
| per_dout | output | DW (16) | Data toward the peripheral |
| per_doe | output | 1 | Output enable for `per_dout` |
| per_din | input | DW (16) | Data from the peripheral |

## Verification
The assertions check properties that must hold in every cycle: the two strobes are never active together and never outside chip select, the address and latched timing word stay fixed while busy, every fall of busy comes with a single-cycle done, and the phase counter stays within its programmed length. Whether each phase lasts exactly its field value plus one, whether the read sample comes from the last strobe cycle and not a neighbouring one, and whether the byte lanes are routed correctly under width and swap only show against the bench's cycle model. The bench drives a read bus pattern that changes every cycle and steps through a range of timing words for this reason.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

    localparam int CFG_W = 14;
    localparam int CNT_W = 4;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    // Packed MSB first: the field positions match the timing word bits.
    typedef struct packed {
        logic       swap;       // bit 13
        logic       wide;       // bit 12
        logic [2:0] setup_len;  // bits 11:9
        logic [3:0] rd_len;     // bits 8:5
        logic [2:0] wr_len;     // bits 4:2
        logic [1:0] hold_len;   // bits 1:0
    } timing_cfg_t;

endpackage

// File: rtl/pio_phase_ctrl.sv
module pio_phase_ctrl
    import pio_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        req_write,
    input  timing_cfg_t cfg_in,
    output phase_e      phase,
    output logic        write,
    output timing_cfg_t cfg,
    output logic        capture,
    output logic        done
);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic               write;
        timing_cfg_t        cfg;
        logic               done;
    } ctrl_state_t;

    ctrl_state_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    d.phase = PH_SETUP;
                    d.cfg   = cfg_in;
                    d.write = req_write;
                    d.cnt   = CNT_W'(cfg_in.setup_len);
                end
            end
            PH_SETUP: begin
                if (q.cnt == '0) begin
                    d.phase = PH_STROBE;
                    d.cnt   = q.write ? CNT_W'(q.cfg.wr_len) : CNT_W'(q.cfg.rd_len);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (q.cnt == '0) begin
                    d.phase = PH_HOLD;
                    d.cnt   = CNT_W'(q.cfg.hold_len);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: begin
                if (q.cnt == '0) begin
                    d.phase = PH_IDLE;
                    d.done  = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, cnt: '0, write: 1'b0, cfg: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign phase   = q.phase;
    assign write   = q.write;
    assign cfg     = q.cfg;
    assign done    = q.done;
    assign capture = (q.phase == PH_STROBE) && (q.cnt == '0) && !q.write;

    logic busy_w;
    assign busy_w = (q.phase != PH_IDLE);

    // R8: done lasts a single cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // R8: every end of an access is marked by done
    a_r8_done_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_w) |-> q.done);

    // R12: the latched timing word does not move while an access runs
    a_r12_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_w |=> $stable(q.cfg));

    // R3 / R4: strobe counter stays within the programmed length
    a_r4_strobe_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_STROBE) |->
            (q.cnt <= (q.write ? CNT_W'(q.cfg.wr_len) : CNT_W'(q.cfg.rd_len))));

endmodule

// File: rtl/pio_data_lane.sv
module pio_data_lane #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] wdata_in,
    input  logic          wide,
    input  logic          swap,
    input  logic          drive,
    input  logic          capture,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic [DW-1:0] rdata
);

    localparam int HB = DW / 2;

    typedef struct packed {
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } lane_state_t;

    lane_state_t q, d;

    function automatic logic [DW-1:0] lane_fmt(input logic [DW-1:0] x,
                                               input logic w, input logic s);
        logic [DW-1:0] r;
        if (!w)      r = {{HB{1'b0}}, x[HB-1:0]};
        else if (s)  r = {x[HB-1:0], x[DW-1:HB]};
        else         r = x;
        return r;
    endfunction

    always_comb begin
        d = q;
        if (load)    d.wdata = wdata_in;
        if (capture) d.rdata = lane_fmt(din, wide, swap);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign dout  = drive ? lane_fmt(q.wdata, wide, swap) : '0;
    assign rdata = q.rdata;

    // R10: the upper lane stays quiet on a narrow write
    a_r10_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && !wide) |-> (dout[DW-1:HB] == '0));

    // R6: the read result only moves on a sample
    a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rdata));

endmodule

// File: rtl/pio_strobe_seq.sv
module pio_strobe_seq
    import pio_seq_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_timing,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    rsp_rdata,
    output logic [AW-1:0]    per_addr,
    output logic             per_cs,
    output logic             per_rd,
    output logic             per_wr,
    output logic [DW-1:0]    per_dout,
    output logic             per_doe,
    input  logic [DW-1:0]    per_din
);

    typedef struct packed {
        logic [AW-1:0] addr;
    } top_state_t;

    top_state_t  q, d;
    phase_e      phase;
    logic        wr_q;
    timing_cfg_t cfg_q;
    logic        capture;
    logic        start;

    assign start = req_valid && !busy;

    pio_phase_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .req_write (req_write),
        .cfg_in    (timing_cfg_t'(cfg_timing)),
        .phase     (phase),
        .write     (wr_q),
        .cfg       (cfg_q),
        .capture   (capture),
        .done      (done)
    );

    pio_data_lane #(.DW(DW)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .wdata_in (req_wdata),
        .wide     (cfg_q.wide),
        .swap     (cfg_q.swap),
        .drive    (per_doe),
        .capture  (capture),
        .din      (per_din),
        .dout     (per_dout),
        .rdata    (rsp_rdata)
    );

    always_comb begin
        d = q;
        if (start) d.addr = req_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy     = (phase != PH_IDLE);
    assign per_cs   = busy;
    assign per_rd   = (phase == PH_STROBE) && !wr_q;
    assign per_wr   = (phase == PH_STROBE) && wr_q;
    assign per_doe  = busy && wr_q;
    assign per_addr = q.addr;

    // R13: strobes exclusive
    a_r13_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(per_rd && per_wr));

    // R13: strobes only inside chip select
    a_r13_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (per_rd || per_wr) |-> per_cs);

    // R9: address held across the access
    a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(per_addr)));

    // R7: never drive data during a read strobe
    a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        per_rd |-> !per_doe);

endmodule

// File: tb/pio_strobe_seq_test.sv
`timescale 1ns/1ps
module pio_strobe_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] cfg_timing = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, per_cs, per_rd, per_wr, per_doe;
    logic [15:0] rsp_rdata, per_dout;
    logic [7:0]  per_addr;
    logic [15:0] per_din = 16'h1234;

    always #2.5 clk = ~clk;

    pio_strobe_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_timing(cfg_timing),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rsp_rdata(rsp_rdata),
        .per_addr(per_addr), .per_cs(per_cs), .per_rd(per_rd), .per_wr(per_wr),
        .per_dout(per_dout), .per_doe(per_doe), .per_din(per_din)
    );

    int checks = 0;
    int errors = 0;

    // reference model: 0 idle, 1 setup, 2 strobe, 3 hold, 4 done
    int          ph_q[$];
    int          cur_ph = 0;
    logic [13:0] m_cfg = '0;
    logic        m_w = 1'b0;
    logic [7:0]  m_addr = '0;
    logic [15:0] m_wdata = '0;
    logic [15:0] m_rdata = '0;
    int          n_setup, n_strobe, n_hold;
    int          seen_setup = 0, seen_strobe = 0, seen_hold = 0;
    logic        in_strobe_done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] fmt(input logic [15:0] x, input logic [13:0] c);
        if (!c[12]) return {8'h00, x[7:0]};
        if (c[13])  return {x[7:0], x[15:8]};
        return x;
    endfunction

    task automatic model_update();
        int prev;
        prev = cur_ph;
        if (prev == 2 && ph_q.size() > 0 && ph_q[0] == 3 && !m_w)
            m_rdata = fmt(per_din, m_cfg);
        if ((prev == 0 || prev == 4) && req_valid) begin
            m_cfg   = cfg_timing;
            m_w     = req_write;
            m_addr  = req_addr;
            m_wdata = req_wdata;
            n_setup  = int'(m_cfg[11:9]) + 1;
            n_strobe = m_w ? int'(m_cfg[4:2]) + 1 : int'(m_cfg[8:5]) + 1;
            n_hold   = int'(m_cfg[1:0]) + 1;
            for (int i = 0; i < n_setup; i++)  ph_q.push_back(1);
            for (int i = 0; i < n_strobe; i++) ph_q.push_back(2);
            for (int i = 0; i < n_hold; i++)   ph_q.push_back(3);
            ph_q.push_back(4);
        end
        cur_ph = (ph_q.size() > 0) ? ph_q.pop_front() : 0;
    endtask

    task automatic compare();
        logic b;
        b = (cur_ph >= 1 && cur_ph <= 3);
        chk("R8 busy", busy, b);
        chk("R8 done", done, cur_ph == 4);
        chk("R2 R5 per_cs", per_cs, b);
        chk("R4 per_rd", per_rd, cur_ph == 2 && !m_w);
        chk("R3 per_wr", per_wr, cur_ph == 2 && m_w);
        chk("R7 per_doe", per_doe, b && m_w);
        chk("R7 R10 R11 per_dout", per_dout, (b && m_w) ? fmt(m_wdata, m_cfg) : 16'h0);
        chk("R9 per_addr", per_addr, m_addr);
        chk("R6 rsp_rdata", rsp_rdata, m_rdata);
        // measured phase widths at the pins
        if (per_cs && !per_rd && !per_wr && !in_strobe_done) seen_setup++;
        if (per_rd || per_wr) begin seen_strobe++; in_strobe_done = 1'b1; end
        if (per_cs && !per_rd && !per_wr && in_strobe_done) seen_hold++;
        if (done) begin
            chk("R2 setup width", seen_setup, n_setup);
            if (m_w) chk("R3 write strobe width", seen_strobe, n_strobe);
            else     chk("R4 read strobe width", seen_strobe, n_strobe);
            chk("R5 hold width", seen_hold, n_hold);
            seen_setup = 0; seen_strobe = 0; seen_hold = 0; in_strobe_done = 1'b0;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        model_update();
        @(negedge clk);
        compare();
        per_din = {per_din[14:0], per_din[15] ^ per_din[13]} ^ 16'h0101;
    endtask

    task automatic run_access(input logic w, input logic [7:0] a, input logic [15:0] dat,
                              input logic [13:0] c, input logic stray, input logic chg);
        cfg_timing = c;
        req_valid  = 1'b1;
        req_write  = w;
        req_addr   = a;
        req_wdata  = dat;
        tick();
        req_valid = 1'b0;
        if (stray) begin
            // R9: request during busy must be ignored
            req_valid = 1'b1; req_write = !w; req_addr = ~a; req_wdata = ~dat;
            tick();
            req_valid = 1'b0;
        end
        if (chg) cfg_timing = ~c;  // R12: mid-access change must have no effect
        while (!done) tick();
    endtask

    logic finished = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 strobes", {per_cs, per_rd, per_wr, per_doe}, 0);
        chk("R1 addr", per_addr, 0);
        chk("R1 dout", per_dout, 0);
        chk("R1 rdata", rsp_rdata, 0);
        rst_n = 1'b1;
        tick(); tick();

        // minimum timing, 16-bit write (R2 R3 R5 R7)
        run_access(1'b1, 8'h11, 16'hA55A, 14'h1000, 1'b0, 1'b0);
        // maximum timing, 16-bit read (R4 R6)
        run_access(1'b0, 8'h22, 16'h0000, 14'h1FFF, 1'b0, 1'b0);
        // 8-bit write and read (R10)
        run_access(1'b1, 8'h33, 16'hABCD, 14'h0A49, 1'b0, 1'b0);
        run_access(1'b0, 8'h34, 16'h0000, 14'h0A49, 1'b0, 1'b0);
        // swap set in 8-bit mode has no effect (R11)
        run_access(1'b1, 8'h35, 16'hBEEF, 14'h2215, 1'b0, 1'b0);
        run_access(1'b0, 8'h36, 16'h0000, 14'h2215, 1'b0, 1'b0);
        // 16-bit swap both ways (R11)
        run_access(1'b1, 8'h44, 16'h1357, 14'h3526, 1'b0, 1'b0);
        run_access(1'b0, 8'h45, 16'h0000, 14'h3526, 1'b0, 1'b0);
        // stray request while busy (R9)
        run_access(1'b0, 8'h55, 16'h0000, 14'h1323, 1'b1, 1'b0);
        run_access(1'b1, 8'h56, 16'h7E81, 14'h1323, 1'b1, 1'b0);
        // timing word changed mid-access (R12)
        run_access(1'b1, 8'h66, 16'hC3C3, 14'h1204, 1'b0, 1'b1);
        run_access(1'b0, 8'h67, 16'h0000, 14'h2461, 1'b0, 1'b1);
        // back-to-back from done cycles, pseudo-random settings
        lf = 32'h1ACE_B00C;
        for (int k = 0; k < 40; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            run_access(lf[0], lf[15:8], lf[31:16], lf[29:16], lf[3] & lf[5], lf[7]);
        end
        tick(); tick();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule